// File: doc/BRIEF.md
# Timer Channel Pin Controller

This block governs the single I/O pin of one general purpose timer channel. A small mode register picks the pin's function. In GPIO function the pin can be driven low or high, and a high level can be made open drain so that it releases the line instead of driving it. In every function the pin is also observed as an input. Its synchronized level can be read back, and a selectable rising, falling or either edge sets an interrupt flag.

Software reaches the block through a word-wide register port with two addresses: the mode register and the status register. The status register shows the pin level and the interrupt flag. Writing a one to the flag position clears the flag. The single interrupt output is the flag gated by an enable bit in the mode register. Counting, compare and PWM generation are handled elsewhere in the timer; the function codes for them only keep the pin undriven here.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset the mode register and status register read 0, pin_oe_o is 0 and irq_o is 0.
- R2: The mode register keeps only its defined fields and reads other bits as 0: function in bits 2:0, output control in bits 5:4, interrupt enable in bit 8, open drain in bit 9, edge select in bits 17:16. Writing all ones reads back 0x00030337.
- R3: With function 4 (GPIO) and output control 10, the pin is driven low (pin_oe_o=1, pin_o=0) from the clock edge that writes the mode.
- R4: With function 4 and output control 11 and open drain 0, the pin is driven high (pin_oe_o=1, pin_o=1).
- R5: With open drain set, output control 11 releases the pin (pin_oe_o=0) and output control 10 still drives it low.
- R6: pin_oe_o is 0 whenever the function is not 4, including input capture (function 1), and whenever output control bit 5 is 0.
- R7: Status bit 8 shows the pin level through a two-flop synchronizer: it follows a change of pin_i on the second rising clock edge after the change.
- R8: Edge select 01 sets the flag (status bit 0) on a rising pin edge only. The flag appears on the third clock edge after the pin changes.
- R9: Edge select 10 sets the flag on a falling edge only; edge select 11 sets it on either edge.
- R10: Edge select 00 never sets the flag.
- R11: Writing the status register with bit 0 set clears the flag on that clock edge; writing it with bit 0 clear leaves the flag unchanged.
- R12: irq_o is high exactly when the flag is set and mode bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 mode, 1 status |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data of the selected register (combinational) |
| pin_i | input | 1 | Pin level from the pad |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin drive enable |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded assertions check these rules: the pin is never enabled outside GPIO function, an open-drain pin is never driven high, the interrupt never fires without its enable, the flag never rises under edge select 00, and a clear with no competing edge empties the flag. The bench's scenarios are needed to show the rest: the exact synchronizer and edge-detect latency, the direction selectivity of each edge code, the readback mask of the mode register, and that a zero write leaves the flag alone.

// File: rtl/tmr_pin_pkg.sv
package tmr_pin_pkg;

  typedef enum logic [2:0] {
    FUNC_OFF  = 3'd0,
    FUNC_ICAP = 3'd1,
    FUNC_OCMP = 3'd2,
    FUNC_PWM  = 3'd3,
    FUNC_GPIO = 3'd4
  } pin_func_e;

  // Field positions are software-visible
  localparam int unsigned FuncLsb  = 0;
  localparam int unsigned GpoLsb   = 4;
  localparam int unsigned IrqEnBit = 8;
  localparam int unsigned OdBit    = 9;
  localparam int unsigned EdgeLsb  = 16;
  localparam int unsigned FlagBit  = 0;
  localparam int unsigned LvlBit   = 8;
  localparam int unsigned MinDw    = EdgeLsb + 2;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       od;
    logic       irq_en;
    logic [1:0] gpo;
    logic [2:0] func;
  } mode_t;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[N-2:0], d_i};
  end

  assign q_o = chain_q[N-1];
endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] edge_sel_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic prev_q, rise, fall, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign evt  = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);

  // a new edge wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (evt)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(edge_sel_i) != 2'b00 && $past(rise | fall))); // R10

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise && !fall) |=> !flag_o); // R11
endmodule

// File: rtl/tmr_pin_drive.sv
module tmr_pin_drive
  import tmr_pin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] func_i,
  input  logic [1:0] gpo_i,
  input  logic       od_i,
  output logic       pin_o,
  output logic       oe_o
);
  logic gpio_out;

  assign gpio_out = (func_i == FUNC_GPIO) && gpo_i[1];

  always_comb begin
    pin_o = 1'b0;
    oe_o  = 1'b0;
    if (gpio_out) begin
      pin_o = gpo_i[0] & ~od_i;
      oe_o  = ~(gpo_i[0] & od_i);
    end
  end

  AST_OE_ONLY_GPIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (func_i == FUNC_GPIO && gpo_i[1])); // R6

  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && od_i) |-> !pin_o); // R5
endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pin_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          pin_i,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          irq_o
);
  localparam int unsigned W = (DW < MinDw) ? MinDw : DW;

  mode_t mode_q;
  logic  lvl, flag, clr;
  logic [W-1:0] wd;

  assign wd  = W'(wdata_i);
  assign clr = wr_en_i && addr_i && wd[FlagBit];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (wr_en_i && !addr_i) begin
      mode_q.func     <= wd[FuncLsb +: 3];
      mode_q.gpo      <= wd[GpoLsb +: 2];
      mode_q.irq_en   <= wd[IrqEnBit];
      mode_q.od       <= wd[OdBit];
      mode_q.edge_sel <= wd[EdgeLsb +: 2];
    end
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  tmr_pin_edge i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .edge_sel_i(mode_q.edge_sel),
    .clr_i     (clr),
    .flag_o    (flag)
  );

  tmr_pin_drive i_drive (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .func_i(mode_q.func),
    .gpo_i (mode_q.gpo),
    .od_i  (mode_q.od),
    .pin_o (pin_o),
    .oe_o  (pin_oe_o)
  );

  assign irq_o = flag & mode_q.irq_en;

  always_comb begin
    logic [W-1:0] rd;
    rd = '0;
    if (!addr_i) begin
      rd[FuncLsb +: 3]  = mode_q.func;
      rd[GpoLsb +: 2]   = mode_q.gpo;
      rd[IrqEnBit]      = mode_q.irq_en;
      rd[OdBit]         = mode_q.od;
      rd[EdgeLsb +: 2]  = mode_q.edge_sel;
    end else begin
      rd[FlagBit] = flag;
      rd[LvlBit]  = lvl;
    end
    rdata_o = rd[DW-1:0];
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mode_q.irq_en); // R12

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && !pin_oe_o)); // R1
endmodule

// File: tb/test_tmr_pin_ctrl.sv
`timescale 1ns/1ps
module test_tmr_pin_ctrl;
  localparam int unsigned DW = 32;
  localparam int OBS_RD = 0, OBS_OE = 1, OBS_PIN = 2, OBS_IRQ = 3;

  typedef struct {
    string       tag;
    int          obs;
    logic [31:0] exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          addr = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          pin_in = 1'b0;
  logic          pin_out, pin_oe, irq;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  tmr_pin_ctrl #(.DW(DW)) i_tmr_pin_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pin_i   (pin_in),
    .pin_o   (pin_out),
    .pin_oe_o(pin_oe),
    .irq_o   (irq)
  );

  // monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.obs)
          OBS_RD:  act = rdata;
          OBS_OE:  act = {31'd0, pin_oe};
          OBS_PIN: act = {31'd0, pin_out};
          default: act = {31'd0, irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string tag, input int obs, input logic [31:0] exp);
    q.push_back('{tag, obs, exp});
    wait (q.size() == 0);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    step(1);
    addr = a; wdata = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0; addr = 1'b1;
  endtask

  task automatic chk_mode(input string tag, input logic [31:0] exp);
    addr = 1'b0;
    expect_val(tag, OBS_RD, exp);
    addr = 1'b1;
  endtask

  task automatic chk_drive(input string tag, input logic oe, input logic p);
    expect_val(tag, OBS_OE, {31'd0, oe});
    if (oe) expect_val(tag, OBS_PIN, {31'd0, p});
  endtask

  task automatic pin_to(input logic v, input string tag, input logic [31:0] exp_status);
    step(1);
    pin_in = v;
    step(3);
    expect_val(tag, OBS_RD, exp_status);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk_mode("R1 mode reset", 32'h0);
    expect_val("R1 status reset", OBS_RD, 32'h0);
    expect_val("R1 oe reset", OBS_OE, 32'h0);
    expect_val("R1 irq reset", OBS_IRQ, 32'h0);

    // R2 readback mask
    wr(1'b0, 32'hFFFF_FFFF);
    chk_mode("R2 mode mask", 32'h0003_0337);
    wr(1'b0, 32'h0);

    // R3 drive low, R4 drive high
    wr(1'b0, 32'h24);
    chk_drive("R3 gpio low", 1'b1, 1'b0);
    wr(1'b0, 32'h34);
    chk_drive("R4 gpio high", 1'b1, 1'b1);

    // R5 open drain
    wr(1'b0, 32'h234);
    chk_drive("R5 od high released", 1'b0, 1'b0);
    wr(1'b0, 32'h224);
    chk_drive("R5 od low driven", 1'b1, 1'b0);

    // R6 no drive
    wr(1'b0, 32'h14);
    chk_drive("R6 gpo input", 1'b0, 1'b0);
    wr(1'b0, 32'h31);
    chk_drive("R6 input capture", 1'b0, 1'b0);
    wr(1'b0, 32'h33);
    chk_drive("R6 pwm function", 1'b0, 1'b0);

    // R7 synchronizer latency, R10 no edge under select 00
    step(1);
    pin_in = 1'b1;
    step(1);
    expect_val("R7 level after one edge", OBS_RD, 32'h000);
    step(1);
    expect_val("R7 level after two edges", OBS_RD, 32'h100);
    step(2);
    expect_val("R10 no flag on rise", OBS_RD, 32'h100);
    pin_to(1'b0, "R10 no flag on fall", 32'h000);

    // R8 rising only
    wr(1'b0, 32'h1_0001);
    pin_to(1'b1, "R8 rise sets flag", 32'h101);
    wr(1'b1, 32'h1);
    expect_val("R11 clear flag", OBS_RD, 32'h100);
    pin_to(1'b0, "R8 fall ignored", 32'h000);

    // R9 falling only, then both
    wr(1'b0, 32'h2_0001);
    pin_to(1'b1, "R9 rise ignored", 32'h100);
    pin_to(1'b0, "R9 fall sets flag", 32'h001);
    wr(1'b1, 32'h1);
    wr(1'b0, 32'h3_0001);
    pin_to(1'b1, "R9 both rise", 32'h101);
    wr(1'b1, 32'h1);
    pin_to(1'b0, "R9 both fall", 32'h001);

    // R11 zero write keeps flag, R12 gating
    wr(1'b1, 32'h0);
    expect_val("R11 zero write keeps flag", OBS_RD, 32'h001);
    expect_val("R12 irq masked", OBS_IRQ, 32'h0);
    wr(1'b0, 32'h3_0101);
    expect_val("R12 irq enabled", OBS_IRQ, 32'h1);
    wr(1'b1, 32'h1);
    expect_val("R12 irq after clear", OBS_IRQ, 32'h0);
    expect_val("R11 status after clear", OBS_RD, 32'h000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule